// File: doc/BRIEF.md
# Dual Multiply Add/Subtract Unit

This block multiplies two operand pairs and merges the two products into one result. A runtime control either adds the second product to the first or subtracts it. A second runtime control chooses whether the operands are two's-complement or unsigned. The widths of the first operand (the multiplicand, A) and the second operand (the multiplier, B) are parameters. Each product is as wide as the two operand widths added together, and the merged result is one bit wider than a product.

There are three register stages: one at the operand inputs, one after the multipliers and one at the result. A parameter keeps or removes each stage. The latency therefore runs from zero to three cycles, and the two controls travel through the same stages as the data they belong to.

The operand input registers also form two shift chains, one for the A operands and one for the B operands. Each chain has a shift-in port and a shift-out port, so several units can be cascaded. A parameter for each operand chooses whether that operand loads from its parallel port or from the previous link of its chain. Four clock-enable lines and four synchronous reset lines are offered. A parameter for each register stage chooses which enable line and which reset line it obeys.

Top module: `dmas_top`

## Requirements
- R1: `result` equals P0 + P1 when `subMode` is 0 and P0 − P1 when `subMode` is 1. P0 = A0×B0 and P1 = A1×B1, each PA+PB bits wide. The result is PA+PB+1 bits wide, in two's complement.
- R2: When `signedMode` is 1, all four operands are read as two's-complement values and the products are sign-extended. When it is 0, all four operands are read as unsigned values and the products are zero-extended.
- R3: The latency from the operand ports to `result` is USE_IN_REG + USE_PIPE_REG + USE_OUT_REG cycles. `signedMode` and `subMode` are delayed by exactly the same number of cycles as the operands they apply to.
- R4: When the selected reset line of a stage is 1 at a rising clock edge, every register in that stage is cleared to zero, whatever its clock enable. As a result, `result`, `shiftOutA` and `shiftOutB` all read 0 after a reset of every stage.
- R5: When the selected clock enable of a stage is 0 and its reset is not asserted, the registers of that stage hold their contents across the clock edge.
- R6: `shiftOutA` and `shiftOutB` carry the A1 and B1 input registers. When A1_FROM_CHAIN or B1_FROM_CHAIN is set, that register loads from the A0 or B0 input register, which delays the operand one more cycle. When A0_FROM_CHAIN or B0_FROM_CHAIN is set, the A0 or B0 register loads from `shiftInA` or `shiftInB`.
- R7: With all three stages bypassed, `result` is a purely combinational function of the current inputs.
- R8: Each stage obeys only the enable line `ceBus[sel]` and the reset line `rstBus[sel]` picked by its parameters. Lines that no stage selects have no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by all register stages |
| ceBus | input | 4 | Four clock-enable lines that the stages choose from |
| rstBus | input | 4 | Four synchronous reset lines that the stages choose from |
| a0 | input | PA | First multiplicand |
| b0 | input | PB | First multiplier |
| a1 | input | PA | Second multiplicand |
| b1 | input | PB | Second multiplier |
| shiftInA | input | PA | Input to the A shift chain |
| shiftInB | input | PB | Input to the B shift chain |
| signedMode | input | 1 | 1 = two's-complement operands, 0 = unsigned operands |
| subMode | input | 1 | 1 = subtract the second product, 0 = add it |
| shiftOutA | output | PA | Output of the A shift chain (the A1 input register) |
| shiftOutB | output | PB | Output of the B shift chain (the B1 input register) |
| result | output | PA+PB+1 | Merged result of the two products |

## Verification
The assertions assume that the reset lines are asserted on the first clock edges and that the clock enables are driven to known values from time zero. Under those assumptions, the hold and clear checks compare only defined register contents.

The bench drives every input only on the falling edge, and at time zero it drives every enable line high together with the resets. Throughout the random run it holds one unselected enable line low and one unselected reset line high, and no selected line changes outside the directed hold and reset sequences.

// File: rtl/dmas_pkg.sv
package dmas_pkg;

  // Strobes that the control module sends to the datapath, one enable and one clear per stage.
  typedef struct packed {
    logic inEn;
    logic inClr;
    logic pipeEn;
    logic pipeClr;
    logic outEn;
    logic outClr;
  } stageStrobe_t;

  localparam int unsigned NUM_SRC = 4;

endpackage

// File: rtl/dmas_ctrl.sv
module dmas_ctrl
  import dmas_pkg::*;
#(
  parameter int unsigned IN_CE_SEL    = 0,
  parameter int unsigned IN_RST_SEL   = 0,
  parameter int unsigned PIPE_CE_SEL  = 1,
  parameter int unsigned PIPE_RST_SEL = 1,
  parameter int unsigned OUT_CE_SEL   = 2,
  parameter int unsigned OUT_RST_SEL  = 2
) (
  input  logic [NUM_SRC-1:0] ceBus,
  input  logic [NUM_SRC-1:0] rstBus,
  output stageStrobe_t       strobe
);

  localparam int unsigned SEL_W = $clog2(NUM_SRC);
  localparam logic [SEL_W-1:0] IN_CE   = SEL_W'(IN_CE_SEL);
  localparam logic [SEL_W-1:0] IN_RST  = SEL_W'(IN_RST_SEL);
  localparam logic [SEL_W-1:0] PIP_CE  = SEL_W'(PIPE_CE_SEL);
  localparam logic [SEL_W-1:0] PIP_RST = SEL_W'(PIPE_RST_SEL);
  localparam logic [SEL_W-1:0] OUT_CE  = SEL_W'(OUT_CE_SEL);
  localparam logic [SEL_W-1:0] OUT_RST = SEL_W'(OUT_RST_SEL);

  // Each stage picks one enable line and one reset line. Clear wins over enable.
  always_comb begin
    strobe.inClr   = rstBus[IN_RST];
    strobe.inEn    = ceBus[IN_CE] & ~rstBus[IN_RST];
    strobe.pipeClr = rstBus[PIP_RST];
    strobe.pipeEn  = ceBus[PIP_CE] & ~rstBus[PIP_RST];
    strobe.outClr  = rstBus[OUT_RST];
    strobe.outEn   = ceBus[OUT_CE] & ~rstBus[OUT_RST];
  end

endmodule

// File: rtl/dmas_datapath.sv
module dmas_datapath
  import dmas_pkg::*;
#(
  parameter int unsigned PA            = 8,
  parameter int unsigned PB            = 6,
  parameter bit          USE_IN_REG    = 1'b1,
  parameter bit          USE_PIPE_REG  = 1'b1,
  parameter bit          USE_OUT_REG   = 1'b1,
  parameter bit          A0_FROM_CHAIN = 1'b0,
  parameter bit          B0_FROM_CHAIN = 1'b0,
  parameter bit          A1_FROM_CHAIN = 1'b0,
  parameter bit          B1_FROM_CHAIN = 1'b0,
  localparam int unsigned PW = PA + PB,
  localparam int unsigned RW = PW + 1
) (
  input  logic         clk,
  input  stageStrobe_t strobe,
  input  logic [PA-1:0] a0,
  input  logic [PB-1:0] b0,
  input  logic [PA-1:0] a1,
  input  logic [PB-1:0] b1,
  input  logic [PA-1:0] shiftInA,
  input  logic [PB-1:0] shiftInB,
  input  logic          signedMode,
  input  logic          subMode,
  output logic [PA-1:0] shiftOutA,
  output logic [PB-1:0] shiftOutB,
  output logic [RW-1:0] result
);

  // ---------------- input stage ----------------
  logic [PA-1:0] a0Src, a1Src, a0Q, a1Q;
  logic [PB-1:0] b0Src, b1Src, b0Q, b1Q;
  logic          sgnI, subI;

  assign a0Src = A0_FROM_CHAIN ? shiftInA : a0;
  assign b0Src = B0_FROM_CHAIN ? shiftInB : b0;
  assign a1Src = A1_FROM_CHAIN ? a0Q : a1;
  assign b1Src = B1_FROM_CHAIN ? b0Q : b1;

  generate
    if (USE_IN_REG) begin : g_inReg
      always_ff @(posedge clk) begin
        if (strobe.inClr) begin
          a0Q  <= '0;
          b0Q  <= '0;
          a1Q  <= '0;
          b1Q  <= '0;
          sgnI <= 1'b0;
          subI <= 1'b0;
        end else if (strobe.inEn) begin
          a0Q  <= a0Src;
          b0Q  <= b0Src;
          a1Q  <= a1Src;
          b1Q  <= b1Src;
          sgnI <= signedMode;
          subI <= subMode;
        end
      end

      AST_IN_CLEAR: assert property (@(posedge clk) disable iff (strobe.inClr)
        $past(strobe.inClr) |-> (shiftOutA == '0 && shiftOutB == '0)); // R4
      AST_IN_HOLD: assert property (@(posedge clk) disable iff (strobe.inClr)
        !strobe.inEn |=> ($stable(shiftOutA) && $stable(shiftOutB))); // R5
      AST_CHAIN_SHIFT: assert property (@(posedge clk) disable iff (strobe.inClr)
        strobe.inEn |=> (shiftOutA == $past(a1Src) && shiftOutB == $past(b1Src))); // R6
    end else begin : g_inByp
      assign a0Q  = a0Src;
      assign b0Q  = b0Src;
      assign a1Q  = a1Src;
      assign b1Q  = b1Src;
      assign sgnI = signedMode;
      assign subI = subMode;
    end
  endgenerate

  assign shiftOutA = a1Q;
  assign shiftOutB = b1Q;

  // ---------------- multipliers ----------------
  function automatic logic [PW-1:0] mulOp(input logic [PA-1:0] x, input logic [PB-1:0] y,
                                          input logic sgn);
    logic signed [PA:0]   xe;
    logic signed [PB:0]   ye;
    logic signed [PW+1:0] full;
    xe   = {sgn & x[PA-1], x};
    ye   = {sgn & y[PB-1], y};
    full = xe * ye;
    return full[PW-1:0];
  endfunction

  logic [PW-1:0] prod0, prod1;
  assign prod0 = mulOp(a0Q, b0Q, sgnI);
  assign prod1 = mulOp(a1Q, b1Q, sgnI);

  // ---------------- pipeline stage ----------------
  logic [PW-1:0] prod0P, prod1P;
  logic          sgnP, subP;

  generate
    if (USE_PIPE_REG) begin : g_pipeReg
      always_ff @(posedge clk) begin
        if (strobe.pipeClr) begin
          prod0P <= '0;
          prod1P <= '0;
          sgnP   <= 1'b0;
          subP   <= 1'b0;
        end else if (strobe.pipeEn) begin
          prod0P <= prod0;
          prod1P <= prod1;
          sgnP   <= sgnI;
          subP   <= subI;
        end
      end
    end else begin : g_pipeByp
      assign prod0P = prod0;
      assign prod1P = prod1;
      assign sgnP   = sgnI;
      assign subP   = subI;
    end
  endgenerate

  // ---------------- add / subtract ----------------
  logic [RW-1:0] ext0, ext1, sumW;
  assign ext0 = {sgnP & prod0P[PW-1], prod0P};
  assign ext1 = {sgnP & prod1P[PW-1], prod1P};
  assign sumW = subP ? (ext0 - ext1) : (ext0 + ext1);

  // ---------------- output stage ----------------
  generate
    if (USE_OUT_REG) begin : g_outReg
      logic [RW-1:0] resQ;
      always_ff @(posedge clk) begin
        if (strobe.outClr)     resQ <= '0;
        else if (strobe.outEn) resQ <= sumW;
      end
      assign result = resQ;

      AST_OUT_CLEAR: assert property (@(posedge clk) disable iff (strobe.outClr)
        $past(strobe.outClr) |-> (result == '0)); // R4
      AST_OUT_HOLD: assert property (@(posedge clk) disable iff (strobe.outClr)
        !strobe.outEn |=> $stable(result)); // R5
      AST_OUT_FOLLOW: assert property (@(posedge clk) disable iff (strobe.outClr)
        strobe.outEn |=> (result == $past(sumW))); // R3
    end else begin : g_outByp
      assign result = sumW;
    end
  endgenerate

endmodule

// File: rtl/dmas_top.sv
module dmas_top
  import dmas_pkg::*;
#(
  parameter int unsigned PA            = 8,
  parameter int unsigned PB            = 6,
  parameter bit          USE_IN_REG    = 1'b1,
  parameter bit          USE_PIPE_REG  = 1'b1,
  parameter bit          USE_OUT_REG   = 1'b1,
  parameter bit          A0_FROM_CHAIN = 1'b0,
  parameter bit          B0_FROM_CHAIN = 1'b0,
  parameter bit          A1_FROM_CHAIN = 1'b0,
  parameter bit          B1_FROM_CHAIN = 1'b0,
  parameter int unsigned IN_CE_SEL     = 0,
  parameter int unsigned IN_RST_SEL    = 0,
  parameter int unsigned PIPE_CE_SEL   = 1,
  parameter int unsigned PIPE_RST_SEL  = 1,
  parameter int unsigned OUT_CE_SEL    = 2,
  parameter int unsigned OUT_RST_SEL   = 2,
  localparam int unsigned RW = PA + PB + 1
) (
  input  logic          clk,
  input  logic [3:0]    ceBus,
  input  logic [3:0]    rstBus,
  input  logic [PA-1:0] a0,
  input  logic [PB-1:0] b0,
  input  logic [PA-1:0] a1,
  input  logic [PB-1:0] b1,
  input  logic [PA-1:0] shiftInA,
  input  logic [PB-1:0] shiftInB,
  input  logic          signedMode,
  input  logic          subMode,
  output logic [PA-1:0] shiftOutA,
  output logic [PB-1:0] shiftOutB,
  output logic [RW-1:0] result
);

  stageStrobe_t strobe;

  dmas_ctrl #(
    .IN_CE_SEL(IN_CE_SEL), .IN_RST_SEL(IN_RST_SEL),
    .PIPE_CE_SEL(PIPE_CE_SEL), .PIPE_RST_SEL(PIPE_RST_SEL),
    .OUT_CE_SEL(OUT_CE_SEL), .OUT_RST_SEL(OUT_RST_SEL)
  ) ctrl_i (
    .ceBus(ceBus), .rstBus(rstBus), .strobe(strobe)
  );

  dmas_datapath #(
    .PA(PA), .PB(PB),
    .USE_IN_REG(USE_IN_REG), .USE_PIPE_REG(USE_PIPE_REG), .USE_OUT_REG(USE_OUT_REG),
    .A0_FROM_CHAIN(A0_FROM_CHAIN), .B0_FROM_CHAIN(B0_FROM_CHAIN),
    .A1_FROM_CHAIN(A1_FROM_CHAIN), .B1_FROM_CHAIN(B1_FROM_CHAIN)
  ) dp_i (
    .clk(clk), .strobe(strobe),
    .a0(a0), .b0(b0), .a1(a1), .b1(b1),
    .shiftInA(shiftInA), .shiftInB(shiftInB),
    .signedMode(signedMode), .subMode(subMode),
    .shiftOutA(shiftOutA), .shiftOutB(shiftOutB), .result(result)
  );

endmodule

// File: tb/dmas_top_tb_top.sv
`timescale 1ns/1ps
module dmas_top_tb_top;

  localparam int PA = 8;
  localparam int PB = 6;
  localparam int RW = PA + PB + 1;
  localparam int N  = 400;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic [3:0] ceBus = 4'hF;
  logic [3:0] rstBus = 4'hF;
  logic [PA-1:0] a0 = '0, a1 = '0, sia = '0;
  logic [PB-1:0] b0 = '0, b1 = '0, sib = '0;
  logic sgn = 1'b0, sub = 1'b0;

  logic [PA-1:0] soA, soAc, soAx;
  logic [PB-1:0] soB, soBc, soBx;
  logic [RW-1:0] res, resC, resX;

  int checks = 0;
  int fails  = 0;

  dmas_top #(.PA(PA), .PB(PB)) dut_i (
    .clk(clk), .ceBus(ceBus), .rstBus(rstBus), .a0(a0), .b0(b0), .a1(a1), .b1(b1),
    .shiftInA(sia), .shiftInB(sib), .signedMode(sgn), .subMode(sub),
    .shiftOutA(soA), .shiftOutB(soB), .result(res));

  // Input stage only, with the second operands taken from the chain.
  dmas_top #(.PA(PA), .PB(PB), .USE_PIPE_REG(1'b0), .USE_OUT_REG(1'b0),
             .A1_FROM_CHAIN(1'b1), .B1_FROM_CHAIN(1'b1)) chain_i (
    .clk(clk), .ceBus(ceBus), .rstBus(rstBus), .a0(a0), .b0(b0), .a1(a1), .b1(b1),
    .shiftInA(sia), .shiftInB(sib), .signedMode(sgn), .subMode(sub),
    .shiftOutA(soAc), .shiftOutB(soBc), .result(resC));

  // Every stage bypassed.
  dmas_top #(.PA(PA), .PB(PB), .USE_IN_REG(1'b0), .USE_PIPE_REG(1'b0),
             .USE_OUT_REG(1'b0)) comb_i (
    .clk(clk), .ceBus(ceBus), .rstBus(rstBus), .a0(a0), .b0(b0), .a1(a1), .b1(b1),
    .shiftInA(sia), .shiftInB(sib), .signedMode(sgn), .subMode(sub),
    .shiftOutA(soAx), .shiftOutB(soBx), .result(resX));

  logic [PA-1:0] va0 [N];
  logic [PA-1:0] va1 [N];
  logic [PB-1:0] vb0 [N];
  logic [PB-1:0] vb1 [N];
  bit            vsg [N];
  bit            vsb [N];

  function automatic logic [RW-1:0] calc(logic [PA-1:0] x0, logic [PB-1:0] y0,
                                         logic [PA-1:0] x1, logic [PB-1:0] y1,
                                         bit sg, bit sb);
    longint p0, p1, r;
    longint ix0 = sg ? longint'($signed(x0)) : longint'(x0);
    longint iy0 = sg ? longint'($signed(y0)) : longint'(y0);
    longint ix1 = sg ? longint'($signed(x1)) : longint'(x1);
    longint iy1 = sg ? longint'($signed(y1)) : longint'(y1);
    p0 = ix0 * iy0;
    p1 = ix1 * iy1;
    r  = sb ? (p0 - p1) : (p0 + p1);
    return r[RW-1:0];
  endfunction

  task automatic check(bit ok, string req, longint act, longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic drive(int k);
    a0 = va0[k]; b0 = vb0[k]; a1 = va1[k]; b1 = vb1[k]; sgn = vsg[k]; sub = vsb[k];
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [RW-1:0] held, e;
    void'($urandom(32'd1234));
    for (int k = 0; k < N; k++) begin
      va0[k] = PA'($urandom); vb0[k] = PB'($urandom);
      va1[k] = PA'($urandom); vb1[k] = PB'($urandom);
      vsg[k] = bit'($urandom); vsb[k] = bit'($urandom);
    end
    // Directed corners: extreme unsigned values, the most negative signed values, and mixed signs.
    va0[0] = 8'hFF; vb0[0] = 6'h3F; va1[0] = 8'hFF; vb1[0] = 6'h3F; vsg[0] = 0; vsb[0] = 0;
    va0[1] = 8'h00; vb0[1] = 6'h00; va1[1] = 8'hFF; vb1[1] = 6'h3F; vsg[1] = 0; vsb[1] = 1;
    va0[2] = 8'h80; vb0[2] = 6'h20; va1[2] = 8'h7F; vb1[2] = 6'h1F; vsg[2] = 1; vsb[2] = 1;
    va0[3] = 8'h80; vb0[3] = 6'h20; va1[3] = 8'h80; vb1[3] = 6'h20; vsg[3] = 1; vsb[3] = 0;
    va0[4] = 8'h80; vb0[4] = 6'h20; va1[4] = 8'h80; vb1[4] = 6'h20; vsg[4] = 0; vsb[4] = 0;
    va0[5] = 8'hFF; vb0[5] = 6'h01; va1[5] = 8'h01; vb1[5] = 6'h3F; vsg[5] = 1; vsb[5] = 1;

    repeat (3) @(negedge clk);
    // R4 reset state
    check(res == '0, "R4 result after reset", res, 0);
    check(soA == '0 && soB == '0, "R4 shift outputs after reset", {soA, soB}, 0);
    // R8: line 3 is selected by no stage; hold its enable low and its reset high during the run.
    rstBus = 4'h8;
    ceBus  = 4'h7;
    @(negedge clk);
    rstBus = 4'h8;

    for (int k = 0; k < N; k++) begin
      @(negedge clk);
      if (k >= 3) begin
        e = calc(va0[k-3], vb0[k-3], va1[k-3], vb1[k-3], vsg[k-3], vsb[k-3]);
        check(res == e, "R1 R2 R3 R8 three-stage result", res, e);
      end
      if (k >= 1) begin
        check(soA == va1[k-1] && soB == vb1[k-1], "R6 shift out follows A1/B1 register",
              {soA, soB}, {va1[k-1], vb1[k-1]});
        e = calc(va0[k-1], vb0[k-1], va1[k-1], vb1[k-1], vsg[k-1], vsb[k-1]);
        check(resX == e, "R7 bypassed result", resX, e);
      end
      if (k >= 2) begin
        e = calc(va0[k-1], vb0[k-1], va0[k-2], vb0[k-2], vsg[k-1], vsb[k-1]);
        check(resC == e, "R6 R3 chained operands one-stage result", resC, e);
        check(soAc == va0[k-2] && soBc == vb0[k-2], "R6 chained shift out",
              {soAc, soBc}, {va0[k-2], vb0[k-2]});
      end
      drive(k);
    end

    // R5 hold: settle on vector 10, freeze every enable, then change the inputs.
    drive(10);
    repeat (4) @(negedge clk);
    held = calc(va0[10], vb0[10], va1[10], vb1[10], vsg[10], vsb[10]);
    check(res == held, "R1 settled value before hold", res, held);
    ceBus = 4'h0;
    drive(20);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(res == held, "R5 result held with enables low", res, held);
      check(soA == va1[10], "R5 shift register held with enables low", soA, va1[10]);
    end
    ceBus = 4'h7;
    repeat (3) @(negedge clk);
    e = calc(va0[20], vb0[20], va1[20], vb1[20], vsg[20], vsb[20]);
    check(res == e, "R5 new value after enables return", res, e);

    // R4 reset in mid-run clears every stage even with the enables high.
    rstBus = 4'hF;
    @(negedge clk);
    check(res == '0, "R4 result cleared", res, 0);
    check(soA == '0 && soB == '0, "R4 shift registers cleared", {soA, soB}, 0);
    rstBus = 4'h0;

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule